// File: doc/BRIEF.md
# Motor Driver Fault and Standby Supervisor

This block sits between the analog sense circuits of a two-phase motor driver and its power stage. It decides when the H-bridges may conduct and when the gate-drive charge pump may run. It watches four things: a standby pin, the two supply-good flags, a thermal trip with its cool-down indication, and a current trip. It keeps both enables low whenever any of these forbids operation.

Thermal and over-current trips are held in latches. Only a standby cycle can release them: the pin goes low for at least one clock, then high again. A thermal latch is released by that cycle only if the junction has cooled below its hysteresis point. The protect status pin reports the thermal latch. Each time operation becomes allowed, the charge pump starts at once. The bridges stay off until a programmable number of clock cycles has passed, which gives the pump time to build its voltage.

Top module: `drv_prot_supervisor`

## Requirements
- R1: While `rst_n` is low and after it is released with no clock edge yet, `bridge_en`, `pump_en` and `prot_out` are 0.
- R2: A clock edge that samples `stby_in` = 0 leaves `pump_en` and `bridge_en` at 0 after that edge.
- R3: A clock edge that samples `vlog_ok` = 0 or `vmot_ok` = 0 leaves `pump_en` and `bridge_en` at 0 after that edge.
- R4: A clock edge that samples `temp_trip` = 1 sets the thermal latch. After that edge `prot_out` = 1 and both enables are 0.
- R5: The thermal latch clears only at an edge that sees a standby rising edge: `stby_in` = 1 now and 0 at the previous edge, with `temp_cool` = 1. A rising edge with `temp_cool` = 0 leaves it set.
- R6: A clock edge that samples `curr_trip` = 1 sets the over-current latch, which forces both enables to 0. `prot_out` does not reflect it. The latch clears at the next standby rising edge, with no cooling condition.
- R7: A trip sampled at the same edge as a clearing standby rising edge wins: the latch stays set.
- R8: `pump_en` is 1 after every edge where the run condition holds. The run condition is: standby high, both supplies good, and no latch set after that edge. `bridge_en` becomes 1 only after the edge at which the run condition has held on SETTLE_CYC consecutive edges. It then stays 1 while the run condition holds.
- R9: Any edge without the run condition restarts the settle count from zero.
- R10: Holding `stby_in` high or low without a rising edge, or losing a supply, does not clear a set latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_in | input | 1 | Standby pin, 1 = run allowed |
| temp_trip | input | 1 | Junction over-temperature flag |
| temp_cool | input | 1 | Junction cooled below hysteresis point |
| curr_trip | input | 1 | Output over-current flag |
| vlog_ok | input | 1 | Logic supply above its release level |
| vmot_ok | input | 1 | Motor supply above its release level |
| bridge_en | output | 1 | H-bridge output enable |
| pump_en | output | 1 | Charge pump enable |
| prot_out | output | 1 | Thermal protection status |

## Verification
The bench builds the supervisor with SETTLE_CYC = 5. With that value the whole settle window, its saturation and its restart can be stepped edge by edge, and each sweep pattern can interrupt the count at every possible position. A sweep drives all 64 combinations of the six control inputs. Each combination is followed by runs of healthy input of different lengths, so every latch set, clear, priority collision and restart point meets both a counting timer and a settled one.

// File: rtl/drv_prot_pkg.sv
package drv_prot_pkg;

    // index of each latched fault kind
    localparam int FLT_THERM = 0;
    localparam int FLT_CURR  = 1;
    localparam int NUM_FLT   = 2;

    typedef struct packed {
        logic lvl;
    } edge_st_t;

    typedef struct packed {
        logic hold;
    } flt_st_t;

    typedef struct packed {
        logic pump;
    } top_st_t;

endpackage

// File: rtl/drv_prot_edge.sv
module drv_prot_edge
    import drv_prot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    edge_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = pin;
        rise     = pin & ~st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/drv_prot_latch.sv
module drv_prot_latch
    import drv_prot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic release_evt,
    input  logic release_ok,
    output logic hold_d,
    output logic hold_q
);
    flt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a trip outranks a release seen in the same cycle
        if (trip)
            st_d.hold = 1'b1;
        else if (release_evt && release_ok)
            st_d.hold = 1'b0;
        hold_d = st_d.hold;
        hold_q = st_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/drv_prot_settle.sv
module drv_prot_settle #(
    parameter int SETTLE_CYC = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(SETTLE_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (cnt_q != LIM)
            cnt_d = cnt_q + 1'b1;
        done = (cnt_q == LIM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/drv_prot_supervisor.sv
module drv_prot_supervisor
    import drv_prot_pkg::*;
#(
    parameter int SETTLE_CYC = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stby_in,
    input  logic temp_trip,
    input  logic temp_cool,
    input  logic curr_trip,
    input  logic vlog_ok,
    input  logic vmot_ok,
    output logic bridge_en,
    output logic pump_en,
    output logic prot_out
);
    logic                stby_rise;
    logic [NUM_FLT-1:0]  flt_trip;
    logic [NUM_FLT-1:0]  flt_ok;
    logic [NUM_FLT-1:0]  flt_d;
    logic [NUM_FLT-1:0]  flt_q;
    logic                run_d;
    logic                settled;
    top_st_t             st_d, st_q;

    drv_prot_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (stby_in),
        .rise  (stby_rise)
    );

    assign flt_trip[FLT_THERM] = temp_trip;
    assign flt_ok[FLT_THERM]   = temp_cool;
    assign flt_trip[FLT_CURR]  = curr_trip;
    assign flt_ok[FLT_CURR]    = 1'b1;

    for (genvar g = 0; g < NUM_FLT; g++) begin : g_flt
        drv_prot_latch u_latch (
            .clk         (clk),
            .rst_n       (rst_n),
            .trip        (flt_trip[g]),
            .release_evt (stby_rise),
            .release_ok  (flt_ok[g]),
            .hold_d      (flt_d[g]),
            .hold_q      (flt_q[g])
        );
    end

    always_comb begin
        run_d     = stby_in & vlog_ok & vmot_ok & ~(|flt_d);
        st_d      = st_q;
        st_d.pump = run_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    drv_prot_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_d),
        .done  (settled)
    );

    assign pump_en   = st_q.pump;
    assign bridge_en = settled;
    assign prot_out  = flt_q[FLT_THERM];

endmodule

// File: rtl/drv_prot_supervisor_chk.sv
module drv_prot_supervisor_chk #(
    parameter int SETTLE_CYC = 25000
) (
    input logic clk,
    input logic rst_n,
    input logic stby_in,
    input logic temp_trip,
    input logic temp_cool,
    input logic curr_trip,
    input logic vlog_ok,
    input logic vmot_ok,
    input logic bridge_en,
    input logic pump_en,
    input logic prot_out
);
    p_stby_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !stby_in |=> (!pump_en && !bridge_en));

    p_supply_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(vlog_ok && vmot_ok) |=> (!pump_en && !bridge_en));

    p_therm_trip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        temp_trip |=> (prot_out && !pump_en && !bridge_en));

    p_therm_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_out) |-> ($past(stby_in) && !$past(stby_in, 2) && $past(temp_cool)));

    p_curr_trip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        curr_trip |=> (!pump_en && !bridge_en));

    p_bridge_needs_pump_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bridge_en |-> pump_en);

    if (SETTLE_CYC > 1) begin : g_delay
        p_settle_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(bridge_en) |-> $past(pump_en));
    end
endmodule

bind drv_prot_supervisor drv_prot_supervisor_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stby_in   (stby_in),
    .temp_trip (temp_trip),
    .temp_cool (temp_cool),
    .curr_trip (curr_trip),
    .vlog_ok   (vlog_ok),
    .vmot_ok   (vmot_ok),
    .bridge_en (bridge_en),
    .pump_en   (pump_en),
    .prot_out  (prot_out)
);

// File: tb/drv_prot_supervisor_tb.sv
module drv_prot_supervisor_tb;
    localparam int N = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stby_in = 1'b0, temp_trip = 1'b0, temp_cool = 1'b0, curr_trip = 1'b0;
    logic vlog_ok = 1'b0, vmot_ok = 1'b0;
    logic bridge_en, pump_en, prot_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // reference state
    bit m_lvl, m_th, m_oc, m_pump;
    int m_cnt;

    always #2 clk = ~clk;

    drv_prot_supervisor #(.SETTLE_CYC(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .stby_in(stby_in), .temp_trip(temp_trip),
        .temp_cool(temp_cool), .curr_trip(curr_trip), .vlog_ok(vlog_ok),
        .vmot_ok(vmot_ok), .bridge_en(bridge_en), .pump_en(pump_en), .prot_out(prot_out)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lvl = 0; m_th = 0; m_oc = 0; m_pump = 0; m_cnt = 0;
        end else begin
            bit rise;
            bit run;
            rise = stby_in && !m_lvl;
            m_lvl = stby_in;
            if (temp_trip) m_th = 1;
            else if (rise && temp_cool) m_th = 0;
            if (curr_trip) m_oc = 1;
            else if (rise) m_oc = 0;
            run = stby_in && vlog_ok && vmot_ok && !m_th && !m_oc;
            m_pump = run;
            if (!run) m_cnt = 0;
            else if (m_cnt < N) m_cnt = m_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, pump_en, m_pump, "pump_en");
        chk(tag, bridge_en, (m_cnt == N), "bridge_en");
        chk(tag, prot_out, m_th, "prot_out");
    endtask

    task automatic drive(input logic s, input logic tt, input logic tc, input logic ct,
                         input logic lo, input logic mo);
        stby_in = s; temp_trip = tt; temp_cool = tc; curr_trip = ct;
        vlog_ok = lo; vmot_ok = mo;
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        #1;
        chk_all(tag);
    endtask

    task automatic healthy(input int n, input string tag);
        drive(1, 0, 0, 0, 1, 1);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        #(4 * 20000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        drive(1, 0, 0, 0, 1, 1);
        #5;
        // R1: held in reset
        chk("R1", pump_en, 1'b0, "pump_en in reset");
        chk("R1", bridge_en, 1'b0, "bridge_en in reset");
        chk("R1", prot_out, 1'b0, "prot_out in reset");
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        chk("R1", pump_en, 1'b0, "pump_en after release");

        // R8: settle window edge by edge, explicit expectations
        for (int i = 1; i <= N + 2; i++) begin
            @(posedge clk); #1;
            chk("R8", pump_en, 1'b1, "pump_en during settle");
            chk("R8", bridge_en, (i >= N), "bridge_en during settle");
        end

        // R2: standby low, then restart R9
        drive(0, 0, 0, 0, 1, 1);
        step("R2");
        chk("R2", pump_en, 1'b0, "pump_en standby");
        healthy(N + 1, "R9");

        // R3: each supply loss
        drive(1, 0, 0, 0, 1, 0);
        step("R3");
        drive(1, 0, 0, 0, 0, 1);
        step("R3");
        healthy(2, "R9");
        drive(1, 0, 0, 0, 0, 1);
        step("R9");
        healthy(N + 1, "R9");

        // R4: thermal trip
        drive(1, 1, 0, 0, 1, 1);
        step("R4");
        chk("R4", prot_out, 1'b1, "prot_out after trip");
        // R10: no toggle, supply loss, standby low alone
        healthy(3, "R10");
        drive(1, 0, 1, 0, 0, 0);
        step("R10");
        drive(0, 0, 1, 0, 1, 1);
        step("R10");
        drive(0, 0, 1, 0, 1, 1);
        step("R10");
        chk("R10", prot_out, 1'b1, "prot_out held");
        // R5: rise while still hot
        drive(1, 0, 0, 0, 1, 1);
        step("R5");
        chk("R5", prot_out, 1'b1, "prot_out hot rise");
        drive(0, 0, 1, 0, 1, 1);
        step("R5");
        drive(1, 0, 1, 0, 1, 1);
        step("R5");
        chk("R5", prot_out, 1'b0, "prot_out cleared");
        healthy(N + 1, "R5");

        // R6: over-current latch and release
        drive(1, 0, 0, 1, 1, 1);
        step("R6");
        chk("R6", prot_out, 1'b0, "prot_out on current trip");
        healthy(2, "R6");
        drive(0, 0, 0, 0, 1, 1);
        step("R6");
        healthy(N + 1, "R6");
        chk("R6", bridge_en, 1'b1, "bridge_en after release");

        // R7: trip and release in the same edge
        drive(0, 0, 1, 0, 1, 1);
        step("R7");
        drive(1, 0, 1, 1, 1, 1);
        step("R7");
        chk("R7", pump_en, 1'b0, "pump_en trip wins");
        drive(0, 0, 1, 0, 1, 1);
        step("R7");
        drive(1, 1, 1, 0, 1, 1);
        step("R7");
        chk("R7", prot_out, 1'b1, "prot_out trip wins");
        drive(0, 0, 1, 0, 1, 1);
        step("R7");
        healthy(N + 1, "R7");

        // sweep: every input combination, then a varied healthy run
        for (int rep = 0; rep < 3; rep++) begin
            for (int c = 0; c < 64; c++) begin
                logic [5:0] v;
                v = c[5:0];
                drive(v[0], v[1], v[2], v[3], v[4], v[5]);
                step("R8");
                drive(0, 0, v[2], 0, 1, 1);
                if (rep == 1) step("R9");
                healthy((c + rep) % (N + 3), "R9");
            end
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule